// File: doc/BRIEF.md
# Configurable-Alignment PWM Channel

This block produces one pulse-width-modulated output from a period value, a duty value, a start-level bit and an alignment bit. A counter advances once per channel tick. The tick comes from one of three sources: a free-running prescaler that divides the system clock by a power of two from 1 to 1024, or one of two linear dividers, each dividing by an integer from 1 to 255. In edge mode the counter climbs and wraps. In symmetric mode it climbs to the period value and comes back down. The symmetric mode puts the pulse in the middle of the period, so that several channels can be given pulses that do not overlap.

Each period the output begins at the programmed start level and changes to the opposite level once the counter reaches the duty value. The period, duty, start-level and alignment settings are copied into working copies only at a period boundary, so a change made while the channel runs never cuts a period short. A one-clock pulse marks the first clock of every new period.

Top module: `cfg_pwm`

## Requirements
- R1: `src_sel` values 0 to 10 make each counter step last 2^`src_sel` clocks. Value 11 takes the step length from `div_a` and value 12 takes it from `div_b`, one step per N clocks. A divider value of 0, or `src_sel` from 13 to 15, stops the counter so that the output holds its level and no period ends.
- R2: In edge mode (`center`=0), with step length T, period value P and duty value D, a period lasts P·T clocks. The output holds the start level for the first D·T clocks and the opposite level for the rest.
- R3: In symmetric mode (`center`=1) a period lasts 2·P·T clocks. The output holds the start level for the first D·T clocks and the last D·T clocks, and the opposite level in between.
- R4: `pol`=1 makes each period start high and `pol`=0 makes it start low. During and after reset the output is low and `period_done` is low.
- R5: A duty value of 0 holds the output at the inverse of the start level for whole periods. A duty value equal to or above the period value holds it at the start level. In both cases the output has no edge.
- R6: Changes to `period`, `duty`, `pol` and `center` made while the channel runs take effect at the first clock of the next period. The period in progress finishes with the old values.
- R7: `period_done` is high for exactly one clock, on the first clock of each new period. It does not pulse on the first period after enabling.
- R8: While `en` is low the counter and dividers are cleared and the output follows the `pol` input after one clock. The first period starts on the clock after the edge that samples `en` high.
- R9: A period value of 0 behaves as a period value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Channel run enable |
| src_sel | input | 4 | Tick source: 0-10 prescaler exponent, 11 divider A, 12 divider B |
| div_a | input | DW | Linear divider A ratio (0 stops it) |
| div_b | input | DW | Linear divider B ratio (0 stops it) |
| period | input | CW | Period value P |
| duty | input | CW | Duty value D |
| pol | input | 1 | Start level of each period |
| center | input | 1 | 1 selects symmetric up/down counting |
| pwm_out | output | 1 | PWM waveform |
| period_done | output | 1 | One-clock pulse on the first clock of each period |

## Verification
A counter that turns at the wrong value or a direction flag that is stuck shows up as a wrong spacing between `period_done` pulses within one period, and each period is compared clock by clock against a computed waveform. A shadow register that loads at the wrong moment changes the output levels inside the period where the settings were written, and the bench checks that period and the following one. A wrong tick source or divider count stretches or shrinks every level run by a whole step length, which is visible in the first period after enabling.

// File: rtl/cfg_pwm.sv
module cfg_pwm #(
  parameter int CW   = 16,
  parameter int DW   = 8,
  parameter int NPRE = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [3:0]    src_sel,
  input  logic [DW-1:0] div_a,
  input  logic [DW-1:0] div_b,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] duty,
  input  logic          pol,
  input  logic          center,
  output logic          pwm_out,
  output logic          period_done
);
  localparam int PW = NPRE - 1;

  logic [PW-1:0] pre;
  logic [DW-1:0] ca, cb;
  logic [CW-1:0] cnt, per_q, dq;
  logic          run, dn, pq, cq, done_q;

  logic [PW:0]   pmask;
  logic          tick_pre, tick_a, tick_b, tick, last_up, wrap, lvl;
  logic [CW-1:0] pe;

  assign pmask    = ((PW+1)'(1) << src_sel) - (PW+1)'(1);
  assign tick_pre = &(pre | ~pmask[PW-1:0]);
  assign tick_a   = (div_a != '0) && (ca == div_a - DW'(1));
  assign tick_b   = (div_b != '0) && (cb == div_b - DW'(1));

  always_comb begin
    if (src_sel < 4'(NPRE))           tick = tick_pre;
    else if (src_sel == 4'(NPRE))     tick = tick_a;
    else if (src_sel == 4'(NPRE + 1)) tick = tick_b;
    else                              tick = 1'b0;
  end

  assign pe      = (per_q == '0) ? CW'(1) : per_q;
  assign last_up = (cnt == pe - CW'(1));
  assign wrap    = tick && (cq ? (dn && cnt == CW'(1)) : last_up);
  assign lvl     = dn ? (cnt <= dq) : (cnt < dq);

  assign pwm_out     = run ? (lvl ? pq : ~pq) : pq;
  assign period_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; pre <= '0; ca <= '0; cb <= '0;
      cnt <= '0; dn <= 1'b0; done_q <= 1'b0;
      per_q <= '0; dq <= '0; pq <= 1'b0; cq <= 1'b0;
    end else if (!en || !run) begin
      run <= en; pre <= '0; ca <= '0; cb <= '0;
      cnt <= '0; dn <= 1'b0; done_q <= 1'b0;
      per_q <= period; dq <= duty; pq <= pol; cq <= center;
    end else begin
      pre    <= pre + PW'(1);
      ca     <= (div_a == '0 || tick_a) ? '0 : ca + DW'(1);
      cb     <= (div_b == '0 || tick_b) ? '0 : cb + DW'(1);
      done_q <= wrap;
      if (wrap) begin
        cnt <= '0; dn <= 1'b0;
        per_q <= period; dq <= duty; pq <= pol; cq <= center;
      end else if (tick) begin
        if (!cq) begin
          cnt <= cnt + CW'(1);
        end else if (!dn) begin
          cnt <= cnt + CW'(1);
          dn  <= last_up;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cfg_pwm_chk.sv
module cfg_pwm_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          pol,
  input logic          run,
  input logic          dn,
  input logic          cq,
  input logic          pq,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] per_q,
  input logic [CW-1:0] dq,
  input logic          pwm_out,
  input logic          period_done
);
  logic [CW-1:0] pe_c;
  assign pe_c = (per_q == '0) ? CW'(1) : per_q;

  assert_left_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cq) |-> (cnt < pe_c));

  assert_center_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cq) |-> (cnt <= pe_c));

  assert_down_only_center_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dn |-> cq);

  assert_zero_duty_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && dq == '0 && $stable(dq) && $stable(pq)) |-> $stable(pwm_out));

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !period_done) |->
      ($stable(per_q) && $stable(dq) && $stable(pq) && $stable(cq)));

  assert_no_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !period_done);

  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_out == $past(pol)));

  always_comb begin
    if (!rst_n) assert_reset_low_R4: assert (!pwm_out || run || pq);
  end
endmodule

bind cfg_pwm cfg_pwm_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .run(run), .dn(dn),
  .cq(cq), .pq(pq), .cnt(cnt), .per_q(per_q), .dq(dq),
  .pwm_out(pwm_out), .period_done(period_done)
);

// File: tb/cfg_pwm_tb.sv
`timescale 1ns/1ps
module cfg_pwm_tb;
  logic clk = 1'b0;
  logic rst_n, en, pol, center;
  logic [3:0]  src_sel;
  logic [7:0]  div_a, div_b;
  logic [15:0] period, duty;
  logic pwm_out, period_done;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cfg_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .src_sel(src_sel), .div_a(div_a),
    .div_b(div_b), .period(period), .duty(duty), .pol(pol), .center(center),
    .pwm_out(pwm_out), .period_done(period_done)
  );

  function automatic int step_len(input int sel, input int da, input int db);
    if (sel <= 10) return 1 << sel;
    if (sel == 11) return da;
    if (sel == 12) return db;
    return 0;
  endfunction

  function automatic int per_len(input int p, input int t, input bit c);
    int pe = (p == 0) ? 1 : p;
    return (c ? 2 : 1) * pe * t;
  endfunction

  function automatic bit exp_lvl(input int i, input int p, input int d, input int t,
                                 input bit pl, input bit c);
    int pe = (p == 0) ? 1 : p;
    int de = (d > pe) ? pe : d;
    bit at_start;
    if (!c) at_start = (i < de * t);
    else    at_start = (i < de * t) || (i >= (2 * pe - de) * t);
    return at_start ? pl : ~pl;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Caller stands at offset 0 of a period. Leaves at offset 0 of the next one.
  task automatic check_period(input int p, input int d, input int t, input bit pl,
                              input bit c, input bit first_done, input string req);
    int len = per_len(p, t, c);
    int bad = 0, bad_i = -1, bad_v = 0, dbad = 0;
    for (int i = 0; i < len; i++) begin
      if (i > 0) step();
      if (pwm_out !== exp_lvl(i, p, d, t, pl, c)) begin
        if (bad == 0) begin bad_i = i; bad_v = pwm_out; end
        bad++;
      end
      if (period_done !== ((i == 0) ? first_done : 1'b0)) dbad++;
    end
    check(bad == 0, {req, " waveform level"}, bad_v,
          (bad_i < 0) ? 0 : int'(exp_lvl(bad_i, p, d, t, pl, c)));
    check(dbad == 0, "R7 no extra period_done", dbad, 0);
    step();
    check(period_done === 1'b1, {req, " period length"}, period_done, 1);
  endtask

  task automatic start(input int sel, input int da, input int db, input int p,
                       input int d, input bit pl, input bit c);
    en = 1'b0;
    step();
    src_sel = 4'(sel); div_a = 8'(da); div_b = 8'(db);
    period = 16'(p); duty = 16'(d); pol = pl; center = c;
    en = 1'b1;
    step();
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && period_done !== 1'b1; i++) step();
    check(period_done === 1'b1, "R7 boundary reached", period_done, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    rst_n = 1'b0; en = 1'b0; pol = 1'b1; center = 1'b0;
    src_sel = 4'd0; div_a = 8'd1; div_b = 8'd1; period = 16'd4; duty = 16'd2;
    repeat (3) step();
    check(pwm_out === 1'b0, "R4 reset output low", pwm_out, 0);
    check(period_done === 1'b0, "R4 reset done low", period_done, 0);
    rst_n = 1'b1;

    // R8 first period from enable, R2 edge mode, R4 high start
    start(0, 1, 1, 4, 1, 1'b1, 1'b0);
    check_period(4, 1, 1, 1'b1, 1'b0, 1'b0, "R8 first period");
    check_period(4, 1, 1, 1'b1, 1'b0, 1'b1, "R2 edge mode");

    // R3 symmetric mode from divider A, R1
    start(11, 3, 1, 3, 2, 1'b0, 1'b1);
    check_period(3, 2, 3, 1'b0, 1'b1, 1'b0, "R3 symmetric divA");
    check_period(3, 2, 3, 1'b0, 1'b1, 1'b1, "R1 divider A step");

    // R1 divider B and prescaler 4
    start(12, 1, 5, 2, 1, 1'b1, 1'b0);
    check_period(2, 1, 5, 1'b1, 1'b0, 1'b0, "R1 divider B step");
    start(2, 1, 1, 3, 2, 1'b1, 1'b1);
    check_period(3, 2, 4, 1'b1, 1'b1, 1'b0, "R1 prescaler by 4");

    // R5 flat outputs
    start(0, 1, 1, 5, 0, 1'b1, 1'b0);
    check_period(5, 0, 1, 1'b1, 1'b0, 1'b0, "R5 zero duty edge");
    start(1, 1, 1, 4, 4, 1'b0, 1'b1);
    check_period(4, 4, 2, 1'b0, 1'b1, 1'b0, "R5 full duty symmetric");
    start(0, 1, 1, 3, 9, 1'b1, 1'b1);
    check_period(3, 9, 1, 1'b1, 1'b1, 1'b0, "R5 duty above period");
    start(0, 1, 1, 6, 0, 1'b0, 1'b1);
    check_period(6, 0, 1, 1'b0, 1'b1, 1'b0, "R5 zero duty symmetric");

    // R9 period 0
    start(0, 1, 1, 0, 1, 1'b1, 1'b0);
    check_period(0, 1, 1, 1'b1, 1'b0, 1'b0, "R9 zero period edge");
    start(1, 1, 1, 0, 0, 1'b1, 1'b1);
    check_period(0, 0, 2, 1'b1, 1'b1, 1'b0, "R9 zero period symmetric");

    // R1 largest prescaler
    start(10, 1, 1, 1, 1, 1'b0, 1'b0);
    check_period(1, 1, 1024, 1'b0, 1'b0, 1'b0, "R1 prescaler 1024");

    // R1 stopped sources
    begin
      int moved = 0, dn_seen = 0;
      start(11, 0, 1, 4, 2, 1'b1, 1'b0);
      for (int i = 0; i < 300; i++) begin
        if (pwm_out !== 1'b1) moved++;
        if (period_done === 1'b1) dn_seen++;
        step();
      end
      check(moved == 0 && dn_seen == 0, "R1 divider zero stops", moved + dn_seen, 0);
      moved = 0; dn_seen = 0;
      start(14, 1, 1, 4, 2, 1'b0, 1'b1);
      for (int i = 0; i < 300; i++) begin
        if (pwm_out !== 1'b0) moved++;
        if (period_done === 1'b1) dn_seen++;
        step();
      end
      check(moved == 0 && dn_seen == 0, "R1 unused source stops", moved + dn_seen, 0);
    end

    // R6 settings change mid-run
    start(0, 1, 1, 5, 2, 1'b1, 1'b0);
    wait_done(20);
    step(); step();
    period = 16'd3; duty = 16'd1; pol = 1'b0; center = 1'b1;
    begin
      int bad = 0;
      for (int i = 2; i < 5; i++) begin
        if (pwm_out !== exp_lvl(i, 5, 2, 1, 1'b1, 1'b0)) bad++;
        if (i < 4) step();
      end
      check(bad == 0, "R6 old settings hold", bad, 0);
    end
    step();
    check(period_done === 1'b1, "R6 old period length", period_done, 1);
    check_period(3, 1, 1, 1'b0, 1'b1, 1'b1, "R6 new settings");

    // R8 idle level follows pol
    en = 1'b0; pol = 1'b1;
    step();
    check(pwm_out === 1'b1, "R8 idle high", pwm_out, 1);
    pol = 1'b0;
    step();
    check(pwm_out === 1'b0, "R8 idle low", pwm_out, 0);
    check(period_done === 1'b0, "R7 idle no done", period_done, 0);

    // Random mix
    for (int n = 0; n < 30; n++) begin
      int sels[6] = '{0, 1, 2, 3, 11, 12};
      int sel = sels[$urandom_range(5)];
      int da  = $urandom_range(1, 5);
      int db  = $urandom_range(1, 5);
      int p   = $urandom_range(1, 12);
      int d   = $urandom_range(0, p + 1);
      bit pl  = 1'($urandom_range(1));
      bit c   = 1'($urandom_range(1));
      int t   = step_len(sel, da, db);
      start(sel, da, db, p, d, pl, c);
      check_period(p, d, t, pl, c, 1'b0, c ? "R3 random" : "R2 random");
      check_period(p, d, t, pl, c, 1'b1, "R7 random repeat");
    end

    en = 1'b0;
    step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule